// File: doc/BRIEF.md
# Video DMA Instruction Sequencer

The sequencer walks a program of 32-bit control words held in instruction memory and turns it into the actions a video capture engine needs. Each instruction is one to four words long. The first word holds a 4-bit opcode, a 12-bit count field and a set of flag bits. A capture program is made of write instructions that place one scan line, or a piece of it, at a destination address. Sync instructions hold the program until the video front end reports a given line. Jumps close the program into a loop. Control-register writes, with or without an explicit bit mask, reach the rest of the engine.

The same flags on any instruction raise two interrupt lines and step a wrapping transfer counter. Software compares a buffer's stamp against this counter with a signed difference to decide which buffers have completed. The flags take effect when the instruction finishes. For a write, that is when the write port reports done. An opcode outside the defined set stops the sequencer with a sticky error until reset.

A one-cycle `go` pulse starts the program at `prog_addr`. The pulse is accepted only while the sequencer is idle.

Top module: `vdma_seq`

## Requirements
- R1: While reset is low and right after it, no request, register strobe or interrupt is active, `xfer_cnt` is zero and `err` is low.
- R2: Words are fetched one per handshake (`fetch_req` and `fetch_valid` high together), starting at `prog_addr` and stepping by 4 bytes. `fetch_addr` is held while `fetch_req` waits. The length of an instruction is taken from opcode bits 31:28 of its first word:
  - write 0x1: 2 words
  - jump 0x7: 2 words
  - register writes 0x9 and 0xB: 3 words
  - control write 0xD: 4 words
  - sync 0x8: 1 word
  - skip 0x2: 1 word
- R3: A write (0x1) drives `wr_req` with these fields until the cycle in which `wr_done` is sampled high, and no word is fetched in the meantime:
  - `wr_addr` = second word
  - `wr_bytes` = bits 11:0
  - `wr_sol` = bit 27
  - `wr_eol` = bit 26
- R4: A jump (0x7) makes the next fetch come from the address in its second word.
- R5: A control write (0xD) gives a one-cycle `reg_we` with `reg_addr`, `reg_data` and `reg_mask` equal to its second, third and fourth words. The 3-word variants (0x9, 0xB) give `reg_addr` and `reg_data` from words two and three, with `reg_mask` all ones.
- R6: A sync (0x8) fetches nothing further until `line_num` equals the low LINE_W bits of its count field. Bit 9 of that field (offset 0x200) marks the second field.
- R7: On instruction completion, flag bit 17 clears `xfer_cnt` and otherwise bit 16 adds one to it. The counter wraps at CNT_W bits and the new value appears in the cycle after completion.
- R8: On instruction completion, flag bit 24 pulses `irq1` and flag bit 25 pulses `irq2`, each for exactly the one cycle after completion.
- R9: Opcodes 0x0, 0x3-0x6, 0xA, 0xC, 0xE and 0xF set `err` at their first-word fetch. The error is sticky, and no word is fetched after it until reset, even if `go` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, accepted while idle |
| prog_addr | input | AW | Byte address of the first instruction |
| fetch_req | output | 1 | Instruction word request |
| fetch_addr | output | AW | Byte address of the requested word |
| fetch_valid | input | 1 | Requested word is on fetch_data |
| fetch_data | input | 32 | Instruction word |
| wr_req | output | 1 | Line write request, held until done |
| wr_addr | output | AW | Destination byte address |
| wr_bytes | output | 12 | Bytes to transfer |
| wr_sol | output | 1 | Piece starts a scan line |
| wr_eol | output | 1 | Piece ends a scan line |
| wr_done | input | 1 | Write request has completed |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 32 | Register address |
| reg_data | output | 32 | Register value |
| reg_mask | output | 32 | Bits of the register to update |
| line_num | input | LINE_W | Current video line, bit 9 selects second field |
| irq1 | output | 1 | First interrupt pulse |
| irq2 | output | 1 | Second interrupt pulse |
| xfer_cnt | output | CNT_W | Wrapping transfer counter |
| err | output | 1 | Sticky undefined-opcode error |

## Verification
The bench samples every output on the falling edge and compares it with the previous falling-edge sample. An interrupt pulse is due in the sample right after the one that showed `wr_done` (for a write) or `reg_we` (for a register write). A counter change is due one sample after the completing edge. `reg_we` is due in the single cycle after the last word of its instruction is fetched. The sync stall is proven by a fetch count that stays fixed for thirty cycles while `line_num` differs only in the field bit, and that moves once the line matches. The opcode sweep waits a fixed sixty cycles per opcode, far beyond the longest instruction, before `err` is compared with the defined set.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
   localparam logic [3:0] OP_WRITE  = 4'h1;
   localparam logic [3:0] OP_SKIP   = 4'h2;
   localparam logic [3:0] OP_JUMP   = 4'h7;
   localparam logic [3:0] OP_SYNC   = 4'h8;
   localparam logic [3:0] OP_REGW   = 4'h9;
   localparam logic [3:0] OP_REGWB  = 4'hB;
   localparam logic [3:0] OP_CTLW   = 4'hD;

   localparam int F_CNT_INC = 16;
   localparam int F_CNT_CLR = 17;
   localparam int F_IRQ_A   = 24;
   localparam int F_IRQ_B   = 25;
   localparam int F_EOL     = 26;
   localparam int F_SOL     = 27;

   localparam int MAX_WORDS = 4;

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_EXEC, S_WRITE, S_SYNC, S_HALT
   } seq_state_e;
endpackage

// File: rtl/vdma_decode.sv
module vdma_decode
   import vdma_pkg::*;
(
   input  logic [3:0] op,
   output logic [2:0] len,
   output logic       legal,
   output logic       is_write,
   output logic       is_jump,
   output logic       is_sync,
   output logic       is_reg,
   output logic       full_mask
);
   always_comb begin
      len       = 3'd1;
      legal     = 1'b1;
      is_write  = 1'b0;
      is_jump   = 1'b0;
      is_sync   = 1'b0;
      is_reg    = 1'b0;
      full_mask = 1'b1;
      case (op)
         OP_WRITE: begin len = 3'd2; is_write = 1'b1; end
         OP_JUMP:  begin len = 3'd2; is_jump  = 1'b1; end
         OP_SYNC:  is_sync = 1'b1;
         OP_SKIP:  ;
         OP_REGW, OP_REGWB: begin len = 3'd3; is_reg = 1'b1; end
         OP_CTLW:  begin len = 3'd4; is_reg = 1'b1; full_mask = 1'b0; end
         default:  legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/vdma_wordbuf.sv
module vdma_wordbuf #(
   parameter int WORDS = 4,
   parameter int DW    = 32,
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [IDX_W-1:0]           idx,
   input  logic [DW-1:0]              din,
   output logic [WORDS-1:0][DW-1:0]   words
);
   for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[g] <= '0;
         else if (load && (idx == IDX_W'(g)))
            words[g] <= din;
      end
   end
endmodule

// File: rtl/vdma_events.sv
module vdma_events #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             do_inc,
   input  logic             do_clr,
   input  logic             want_a,
   input  logic             want_b,
   output logic [CNT_W-1:0] cnt,
   output logic             irq_a,
   output logic             irq_b
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         irq_a <= 1'b0;
         irq_b <= 1'b0;
      end else begin
         irq_a <= fire & want_a;
         irq_b <= fire & want_b;
         if (fire) begin
            if (do_clr)
               cnt <= '0;
            else if (do_inc)
               cnt <= cnt + 1'b1;
         end
      end
   end

   assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + 1'b1) || (cnt == '0)));

   assert_irq1_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a |=> !irq_a);

   assert_irq2_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_b |=> !irq_b);
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
   import vdma_pkg::*;
#(
   parameter int AW     = 32,
   parameter int CNT_W  = 16,
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [AW-1:0]     prog_addr,
   output logic              fetch_req,
   output logic [AW-1:0]     fetch_addr,
   input  logic              fetch_valid,
   input  logic [31:0]       fetch_data,
   output logic              wr_req,
   output logic [AW-1:0]     wr_addr,
   output logic [11:0]       wr_bytes,
   output logic              wr_sol,
   output logic              wr_eol,
   input  logic              wr_done,
   output logic              reg_we,
   output logic [31:0]       reg_addr,
   output logic [31:0]       reg_data,
   output logic [31:0]       reg_mask,
   input  logic [LINE_W-1:0] line_num,
   output logic              irq1,
   output logic              irq2,
   output logic [CNT_W-1:0]  xfer_cnt,
   output logic              err
);
   localparam int IDX_W = $clog2(MAX_WORDS);

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("vdma_seq: AW must lie in 8..32");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("vdma_seq: CNT_W must lie in 2..32");
   end
   if (LINE_W < 1 || LINE_W > 12) begin : g_bad_line
      $error("vdma_seq: LINE_W must lie in 1..12");
   end

   seq_state_e                   st;
   logic [AW-1:0]                pc;
   logic [IDX_W-1:0]             idx;
   logic [2:0]                   len_q;
   logic                         err_q;
   logic [MAX_WORDS-1:0][31:0]   words;

   logic [3:0] dec_op;
   logic [2:0] dec_len;
   logic       dec_legal, dec_write, dec_jump, dec_sync, dec_reg, dec_full;
   logic       first_word, last_word, line_hit, fire;
   logic [2:0] cur_len;

   assign first_word = (idx == '0);
   assign dec_op     = (st == S_FETCH && first_word) ? fetch_data[31:28] : words[0][31:28];

   vdma_decode u_dec (
      .op        (dec_op),
      .len       (dec_len),
      .legal     (dec_legal),
      .is_write  (dec_write),
      .is_jump   (dec_jump),
      .is_sync   (dec_sync),
      .is_reg    (dec_reg),
      .full_mask (dec_full)
   );

   vdma_wordbuf #(.WORDS(MAX_WORDS), .DW(32)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (st == S_FETCH && fetch_valid),
      .idx   (idx),
      .din   (fetch_data),
      .words (words)
   );

   assign cur_len   = first_word ? dec_len : len_q;
   assign last_word = ({1'b0, idx} + 3'd1) == cur_len;
   assign line_hit  = (line_num == words[0][LINE_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         pc    <= '0;
         idx   <= '0;
         len_q <= 3'd1;
         err_q <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (go) begin
               pc  <= prog_addr;
               idx <= '0;
               st  <= S_FETCH;
            end
            S_FETCH: if (fetch_valid) begin
               if (first_word && !dec_legal) begin
                  st    <= S_HALT;
                  err_q <= 1'b1;
               end else begin
                  pc <= pc + AW'(4);
                  if (first_word)
                     len_q <= dec_len;
                  if (last_word) begin
                     idx <= '0;
                     st  <= S_EXEC;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            S_EXEC: begin
               if (dec_write)
                  st <= S_WRITE;
               else if (dec_sync)
                  st <= S_SYNC;
               else begin
                  if (dec_jump)
                     pc <= words[1][AW-1:0];
                  st <= S_FETCH;
               end
            end
            S_WRITE: if (wr_done) st <= S_FETCH;
            S_SYNC:  if (line_hit) st <= S_FETCH;
            default: st <= st;
         endcase
      end
   end

   assign fire = (st == S_EXEC && !dec_write && !dec_sync)
              || (st == S_WRITE && wr_done)
              || (st == S_SYNC && line_hit);

   vdma_events #(.CNT_W(CNT_W)) u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire),
      .do_inc (words[0][F_CNT_INC]),
      .do_clr (words[0][F_CNT_CLR]),
      .want_a (words[0][F_IRQ_A]),
      .want_b (words[0][F_IRQ_B]),
      .cnt    (xfer_cnt),
      .irq_a  (irq1),
      .irq_b  (irq2)
   );

   assign fetch_req  = (st == S_FETCH);
   assign fetch_addr = pc;
   assign wr_req     = (st == S_WRITE);
   assign wr_addr    = words[1][AW-1:0];
   assign wr_bytes   = words[0][11:0];
   assign wr_sol     = words[0][F_SOL];
   assign wr_eol     = words[0][F_EOL];
   assign reg_we     = (st == S_EXEC) && dec_reg;
   assign reg_addr   = words[1];
   assign reg_data   = words[2];
   assign reg_mask   = dec_full ? '1 : words[3];
   assign err        = err_q;

   logic unused_bits;
   assign unused_bits = ^{words[0][23:18], words[0][15:12], words[1]};

   assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_valid) |=> (fetch_req && $stable(fetch_addr)));

   assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_bytes)));

   assert_no_fetch_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> !fetch_req);

   assert_reg_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   assert_sync_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_SYNC && !line_hit) |=> !fetch_req);

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> (err && !fetch_req));
endmodule

// File: tb/vdma_seq_bench.sv
`timescale 1ns/1ps
module vdma_seq_bench;
   localparam int CW = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, go, fetch_req, fetch_valid, wr_req, wr_sol, wr_eol, wr_done;
   logic        reg_we, irq1, irq2, err;
   logic [31:0] prog_addr, fetch_addr, fetch_data, wr_addr, reg_addr, reg_data, reg_mask;
   logic [11:0] wr_bytes;
   logic [9:0]  line_num;
   logic [CW-1:0] xfer_cnt;

   vdma_seq #(.AW(32), .CNT_W(CW), .LINE_W(10)) u_vdma_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .prog_addr(prog_addr),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
      .fetch_data(fetch_data), .wr_req(wr_req), .wr_addr(wr_addr), .wr_bytes(wr_bytes),
      .wr_sol(wr_sol), .wr_eol(wr_eol), .wr_done(wr_done), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_data(reg_data), .reg_mask(reg_mask),
      .line_num(line_num), .irq1(irq1), .irq2(irq2), .xfer_cnt(xfer_cnt), .err(err));

   logic [31:0] mem [0:63];
   logic [3:0]  wc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_valid <= 1'b0;
         fetch_data  <= '0;
         wr_done     <= 1'b0;
         wc          <= '0;
      end else begin
         fetch_valid <= fetch_req && !fetch_valid;
         fetch_data  <= mem[fetch_addr[7:2]];
         if (!wr_req || wr_done) begin
            wc <= '0;
            wr_done <= 1'b0;
         end else begin
            wc <= wc + 1'b1;
            wr_done <= (wc == 4'd2);
         end
      end
   end

   logic        clr_logs;
   int          fcount, wcount, rcount, ccount, hold_bad;
   int          irq1_n, irq2_n, irq1_ok, irq2_ok;
   logic [31:0] flog [0:63];
   logic [31:0] wa_log [0:7];
   logic [13:0] wf_log [0:7];
   logic [31:0] ra_log [0:7], rd_log [0:7], rm_log [0:7];
   logic [CW-1:0] clog [0:31];
   logic        p_wr, p_done, p_we;
   logic [31:0] p_wa;
   logic [CW-1:0] p_cnt;

   always @(negedge clk) begin
      if (clr_logs) begin
         fcount <= 0; wcount <= 0; rcount <= 0; ccount <= 0; hold_bad <= 0;
         irq1_n <= 0; irq2_n <= 0; irq1_ok <= 0; irq2_ok <= 0;
         p_wr <= 0; p_done <= 0; p_we <= 0; p_wa <= 0; p_cnt <= 0;
      end else begin
         if (fetch_req && fetch_valid && fcount < 64) begin
            flog[fcount] <= fetch_addr;
            fcount <= fcount + 1;
         end
         if (wr_req && !p_wr && wcount < 8) begin
            wa_log[wcount] <= wr_addr;
            wf_log[wcount] <= {wr_sol, wr_eol, wr_bytes};
            wcount <= wcount + 1;
         end
         if (wr_req && p_wr && wr_addr != p_wa)
            hold_bad <= hold_bad + 1;
         if (reg_we && rcount < 8) begin
            ra_log[rcount] <= reg_addr;
            rd_log[rcount] <= reg_data;
            rm_log[rcount] <= reg_mask;
            rcount <= rcount + 1;
         end
         if (xfer_cnt != p_cnt && ccount < 32) begin
            clog[ccount] <= xfer_cnt;
            ccount <= ccount + 1;
         end
         if (irq1) begin
            irq1_n <= irq1_n + 1;
            if (p_done) irq1_ok <= irq1_ok + 1;
         end
         if (irq2) begin
            irq2_n <= irq2_n + 1;
            if (p_we) irq2_ok <= irq2_ok + 1;
         end
         p_wr <= wr_req; p_done <= wr_done; p_we <= reg_we;
         p_wa <= wr_addr; p_cnt <= xfer_cnt;
      end
   end

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; clr_logs = 1'b1; go = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; clr_logs = 1'b0;
   endtask

   task automatic start(input logic [31:0] a);
      @(negedge clk);
      prog_addr = a; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
   endtask

   task automatic wait_fetch(input int n);
      for (int i = 0; i < 1000 && fcount < n; i++) @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   logic [31:0] exp_f [0:17];

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
      mem[0]  = 32'h1D010064; mem[1]  = 32'h10000000;
      mem[2]  = 32'h18000040; mem[3]  = 32'h00002000;
      mem[4]  = 32'h14000024; mem[5]  = 32'h00002040;
      mem[6]  = 32'hD2000000; mem[7]  = 32'h00000040;
      mem[8]  = 32'hAAAA5555; mem[9]  = 32'h0000FFFF;
      mem[10] = 32'h90000000; mem[11] = 32'h00000044; mem[12] = 32'h12345678;
      mem[13] = 32'h80010205;
      mem[14] = 32'h70010000; mem[15] = 32'h00000080;
      mem[32] = 32'h20020000; mem[33] = 32'hF0000000;
      mem[48] = 32'h10010004; mem[49] = 32'h00000300;
      mem[50] = 32'h70000000; mem[51] = 32'h000000C0;
      mem[57] = 32'h200000E0; mem[58] = 32'h200000E0; mem[59] = 32'h200000E0;
      mem[60] = 32'h70000000; mem[61] = 32'h200000E0;
      for (int i = 0; i < 16; i++) exp_f[i] = 32'(4 * i);
      exp_f[16] = 32'h80; exp_f[17] = 32'h84;

      rst_n = 1'b0; go = 1'b0; prog_addr = '0; line_num = 10'h005; clr_logs = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 reset outputs", {28'd0, fetch_req, wr_req, reg_we, irq1 | irq2}, 32'd0);
      chk("R1 reset counter", 32'(xfer_cnt), 32'd0);
      chk("R1 reset err", 32'(err), 32'd0);
      rst_n = 1'b1; clr_logs = 1'b0;

      start(32'h0);
      wait_fetch(14);
      repeat (30) @(negedge clk);
      chk("R6 stall on field bit mismatch", 32'(fcount), 32'd14);
      chk("R3 write count", 32'(wcount), 32'd3);
      chk("R3 write0 addr", wa_log[0], 32'h10000000);
      chk("R3 write0 flags", 32'(wf_log[0]), {18'd0, 2'b11, 12'd100});
      chk("R3 split head addr", wa_log[1], 32'h2000);
      chk("R3 split head flags", 32'(wf_log[1]), {18'd0, 2'b10, 12'd64});
      chk("R3 split tail addr", wa_log[2], 32'h2040);
      chk("R3 split tail flags", 32'(wf_log[2]), {18'd0, 2'b01, 12'd36});
      chk("R3 held fields", 32'(hold_bad), 32'd0);
      chk("R5 reg count", 32'(rcount), 32'd2);
      chk("R5 ctl addr", ra_log[0], 32'h40);
      chk("R5 ctl data", rd_log[0], 32'hAAAA5555);
      chk("R5 ctl mask", rm_log[0], 32'h0000FFFF);
      chk("R5 short addr", ra_log[1], 32'h44);
      chk("R5 short data", rd_log[1], 32'h12345678);
      chk("R5 short mask", rm_log[1], 32'hFFFFFFFF);

      line_num = 10'h205;
      for (int i = 0; i < 500 && !err; i++) @(negedge clk);
      repeat (10) @(negedge clk);
      chk("R9 err set", 32'(err), 32'd1);
      chk("R2 fetch count", 32'(fcount), 32'd18);
      for (int i = 0; i < 16; i++) chk("R2 fetch address", flog[i], exp_f[i]);
      chk("R4 jump target", flog[16], exp_f[16]);
      chk("R4 after jump", flog[17], exp_f[17]);
      chk("R7 counter steps", 32'(ccount), 32'd4);
      chk("R7 inc on write", 32'(clog[0]), 32'd1);
      chk("R7 inc on sync", 32'(clog[1]), 32'd2);
      chk("R7 inc on jump", 32'(clog[2]), 32'd3);
      chk("R7 clear", 32'(clog[3]), 32'd0);
      chk("R8 irq1 count", 32'(irq1_n), 32'd1);
      chk("R8 irq1 after done", 32'(irq1_ok), 32'd1);
      chk("R8 irq2 count", 32'(irq2_n), 32'd1);
      chk("R8 irq2 after strobe", 32'(irq2_ok), 32'd1);
      start(32'h0);
      repeat (20) @(negedge clk);
      chk("R9 go ignored after error", 32'(fcount), 32'd18);
      chk("R9 still set", 32'(err), 32'd1);

      do_reset();
      chk("R1 err cleared", 32'(err), 32'd0);
      chk("R1 counter cleared", 32'(xfer_cnt), 32'd0);
      start(32'hC0);
      for (int i = 0; i < 2000 && ccount < 17; i++) @(negedge clk);
      chk("R7 wrap count", 32'(ccount), 32'd17);
      chk("R7 top value", 32'(clog[14]), 32'd15);
      chk("R7 wrap to zero", 32'(clog[15]), 32'd0);
      chk("R7 after wrap", 32'(clog[16]), 32'd1);

      line_num = 10'h000;
      for (int op = 0; op < 16; op++) begin
         mem[56] = {4'(op), 28'd0};
         do_reset();
         start(32'hE0);
         repeat (60) @(negedge clk);
         chk($sformatf("R9 opcode %h error flag", op), 32'(err),
             32'((op == 1 || op == 2 || op == 7 || op == 8 ||
                  op == 9 || op == 11 || op == 13) ? 0 : 1));
      end

      finish_run();
   end
endmodule